// File: doc/BRIEF.md
# Asymmetric Phase-Shift PWM Generator

This block drives three complementary switch pairs from one shared period counter. It is meant for phase-shifted bridge converters and for loads whose pulses should not all start together. Six value registers hold the compare points, two for each pair. A modulus register sets the period. The counter runs in one of two geometries. In center-aligned operation it counts up and then back down. In edge-aligned operation it counts up and wraps to zero.

Each pair has two optional modes. In center-aligned operation, the asymmetric mode picks one value register while the counter rises and the other while it falls, which moves the pulse off center. In edge-aligned operation, the XOR mode combines two threshold comparisons, so one value opens the pulse and the other closes it, at any place in the period. The raw pair signal then goes through complementary generation and a programmable dead-time gap. A one-clock reload synchronisation pulse marks the start of every period and can start downstream sampling.

Software programs the block through a simple write port. A global run enable starts and stops the counter.

Top module: `pwm_phase_shift`

## Requirements
- R1: The counter state machine has the states IDLE, UP, DOWN and EDGE. With effective modulus M (the modulus register, where values below 2 are taken as 2):
  - UP goes to DOWN when the count reaches M-1.
  - DOWN goes to UP (or to EDGE if edge mode is now selected) when the count reaches 0.
  - EDGE wraps from M-1 to 0, staying in EDGE or going to UP according to the mode bit.
  - The count therefore runs 0..M-1..0 with period 2(M-1) in center mode, and 0..M-1 with period M in edge mode.
- R2: `sync_pulse` is high for exactly one clock whenever the counter is running (not IDLE) and the count is 0, that is, once per period.
- R3: In center mode with the pair's asymmetric bit clear, the raw signal of pair k is high while value register 2k is greater than the count.
- R4: In center mode with the pair's asymmetric bit set, the comparison uses value 2k in state UP (this includes count 0) and value 2k+1 in state DOWN (this includes count M-1).
- R5: In edge mode, the raw signal of pair k is (count >= value 2k) XOR (count >= value 2k+1) when the pair's XOR bit is set. Otherwise it is value 2k > count.
- R6: `pwm_out[2k]` follows the raw signal and `pwm_out[2k+1]` follows its inverse, one clock after the raw signal changes.
- R7: After every change of a pair's raw signal, both outputs of that pair stay low for D clocks, where D is the dead-time register. A further change during the gap restarts the gap.
- R8: While `run_en` is low, all outputs are low in the same cycle and the counter returns to IDLE with count 0 at the next edge. After `run_en` is raised, the count starts again at 0.
- R9: A pair whose enable bit is clear holds both of its outputs low.
- R10: Register map (address: content). 0..5: value registers. 6: modulus. 7: mode, where bit 0 selects edge mode, bits 1..3 are the asymmetric bits of pairs 0..2, and bits 4..6 are the XOR bits of pairs 0..2. 8: dead time (bits 7:0). 9: pair enables (bits 2:0). Reset clears every register, and the outputs are low after reset.
- R11: The two outputs of a pair are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global run enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | Pair k drives bit 2k (top) and bit 2k+1 (bottom) |
| sync_pulse | output | 1 | One-clock pulse at the start of each period |

## Verification
The hardest situation to reach from the ports is a raw edge that lands while an earlier dead-time gap is still counting down. In that case the gap must restart and a short pulse must vanish completely. To reach it, the stimulus programs small moduli together with value pairs that make pulses narrower than the dead time, and it sweeps every mode and two dead times over a small period. The bench also forces the modulus clamp by writing a modulus of zero, in both center and edge geometry.

// File: rtl/pwm_ps_pkg.sv
package pwm_ps_pkg;

    typedef enum logic [1:0] {
        CNT_IDLE = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2,
        CNT_EDGE = 2'd3
    } cnt_state_t;

    // Fixed offsets inside the register block, relative to the value count
    localparam int OFS_MOD  = 0;
    localparam int OFS_MODE = 1;
    localparam int OFS_DT   = 2;
    localparam int OFS_EN   = 3;
    localparam int NUM_CTRL = 4;

endpackage

// File: rtl/pwm_ps_regs.sv
module pwm_ps_regs
    import pwm_ps_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     val_o [2*NUM_PAIRS],
    output logic [CNT_W-1:0]     mod_o,
    output logic                 edge_mode_o,
    output logic [NUM_PAIRS-1:0] asym_o,
    output logic [NUM_PAIRS-1:0] xor_o,
    output logic [DT_W-1:0]      dt_o,
    output logic [NUM_PAIRS-1:0] pair_en_o
);

    localparam int NVAL   = 2 * NUM_PAIRS;
    localparam int MODE_W = 1 + 2 * NUM_PAIRS;
    localparam int A_MOD  = NVAL + OFS_MOD;
    localparam int A_MODE = NVAL + OFS_MODE;
    localparam int A_DT   = NVAL + OFS_DT;
    localparam int A_EN   = NVAL + OFS_EN;

    logic [CNT_W-1:0]     val_q [NVAL];
    logic [CNT_W-1:0]     mod_q;
    logic [MODE_W-1:0]    mode_q;
    logic [DT_W-1:0]      dt_q;
    logic [NUM_PAIRS-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NVAL; i++) begin
                val_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NVAL; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    val_q[i] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q  <= '0;
            mode_q <= '0;
            dt_q   <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_MOD)) begin
                mod_q <= wr_data;
            end
            if (wr_addr == ADDR_W'(A_MODE)) begin
                mode_q <= wr_data[MODE_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_DT)) begin
                dt_q <= wr_data[DT_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_EN)) begin
                en_q <= wr_data[NUM_PAIRS-1:0];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NVAL; i++) begin
            val_o[i] = val_q[i];
        end
    end

    assign mod_o       = mod_q;
    assign edge_mode_o = mode_q[0];
    assign asym_o      = mode_q[NUM_PAIRS:1];
    assign xor_o       = mode_q[2*NUM_PAIRS:NUM_PAIRS+1];
    assign dt_o        = dt_q;
    assign pair_en_o   = en_q;

endmodule

// File: rtl/pwm_ps_counter.sv
module pwm_ps_counter
    import pwm_ps_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             edge_mode,
    input  logic [CNT_W-1:0] mod_eff,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic             edge_o,
    output logic             running_o,
    output logic             sync_o
);

    cnt_state_t       state_q, state_d, restart_state;
    logic [CNT_W-1:0] cnt_q, cnt_d, top_val, cnt_inc, cnt_dec;

    always_comb begin
        top_val       = mod_eff - 1'b1;
        cnt_inc       = cnt_q + 1'b1;
        cnt_dec       = cnt_q - 1'b1;
        restart_state = edge_mode ? CNT_EDGE : CNT_UP;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CNT_IDLE: begin
                cnt_d = '0;
                if (run_en) begin
                    state_d = restart_state;
                end
            end
            CNT_UP: begin
                cnt_d = cnt_inc;
                if (cnt_inc >= top_val) begin
                    state_d = CNT_DOWN;
                end
            end
            CNT_DOWN: begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_d   = '0;
                    state_d = restart_state;
                end else begin
                    cnt_d = cnt_dec;
                end
            end
            CNT_EDGE: begin
                if (cnt_q >= top_val) begin
                    cnt_d   = '0;
                    state_d = restart_state;
                end else begin
                    cnt_d = cnt_inc;
                end
            end
            default: begin
                state_d = CNT_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (!run_en) begin
            state_d = CNT_IDLE;
            cnt_d   = '0;
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process
    always_comb begin
        cnt_o     = cnt_q;
        up_o      = (state_q == CNT_UP);
        edge_o    = (state_q == CNT_EDGE);
        running_o = (state_q != CNT_IDLE);
        sync_o    = (state_q != CNT_IDLE) && (cnt_q == '0);
    end

endmodule

// File: rtl/pwm_ps_pair_cmp.sv
module pwm_ps_pair_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic             edge_geom,
    input  logic             asym_en,
    input  logic             xor_en,
    input  logic [CNT_W-1:0] val_even,
    input  logic [CNT_W-1:0] val_odd,
    output logic             raw_o
);

    logic [CNT_W-1:0] center_sel;
    logic             ge_even, ge_odd;

    always_comb begin
        center_sel = (asym_en && !up) ? val_odd : val_even;
        ge_even    = (cnt >= val_even);
        ge_odd     = (cnt >= val_odd);
        if (edge_geom) begin
            raw_o = xor_en ? (ge_even ^ ge_odd) : !ge_even;
        end else begin
            raw_o = (center_sel > cnt);
        end
    end

endmodule

// File: rtl/pwm_ps_deadtime.sv
module pwm_ps_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            act,
    input  logic            raw,
    input  logic [DT_W-1:0] dt,
    output logic            hi_o,
    output logic            lo_o
);

    logic            raw_q, act_q;
    logic [DT_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            act_q <= 1'b0;
            gap_q <= '0;
        end else if (!act) begin
            raw_q <= 1'b0;
            act_q <= 1'b0;
            gap_q <= '0;
        end else begin
            act_q <= 1'b1;
            raw_q <= raw;
            if (raw != raw_q) begin
                gap_q <= dt;
            end else if (gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign hi_o = run_en && act_q && raw_q && (gap_q == '0);
    assign lo_o = run_en && act_q && !raw_q && (gap_q == '0);

endmodule

// File: rtl/pwm_phase_shift.sv
module pwm_phase_shift
    import pwm_ps_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 8,
    parameter int ADDR_W    = $clog2(2 * NUM_PAIRS + NUM_CTRL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [CNT_W-1:0]       wr_data,
    output logic [2*NUM_PAIRS-1:0] pwm_out,
    output logic                   sync_pulse
);

    localparam int NVAL = 2 * NUM_PAIRS;

    logic [CNT_W-1:0]     val_w [NVAL];
    logic [CNT_W-1:0]     mod_w, mod_eff, cnt_w;
    logic                 edge_mode_w, up_w, edge_geom_w, running_w;
    logic [NUM_PAIRS-1:0] asym_w, xor_w, pair_en_w;
    logic [DT_W-1:0]      dt_w;

    pwm_ps_regs #(
        .CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS), .DT_W(DT_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .val_o       (val_w),
        .mod_o       (mod_w),
        .edge_mode_o (edge_mode_w),
        .asym_o      (asym_w),
        .xor_o       (xor_w),
        .dt_o        (dt_w),
        .pair_en_o   (pair_en_w)
    );

    assign mod_eff = (mod_w < CNT_W'(2)) ? CNT_W'(2) : mod_w;

    pwm_ps_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .edge_mode (edge_mode_w),
        .mod_eff   (mod_eff),
        .cnt_o     (cnt_w),
        .up_o      (up_w),
        .edge_o    (edge_geom_w),
        .running_o (running_w),
        .sync_o    (sync_pulse)
    );

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        logic raw_k;

        pwm_ps_pair_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt       (cnt_w),
            .up        (up_w),
            .edge_geom (edge_geom_w),
            .asym_en   (asym_w[k]),
            .xor_en    (xor_w[k]),
            .val_even  (val_w[2*k]),
            .val_odd   (val_w[2*k+1]),
            .raw_o     (raw_k)
        );

        pwm_ps_deadtime #(.DT_W(DT_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (run_en),
            .act    (running_w && pair_en_w[k]),
            .raw    (raw_k),
            .dt     (dt_w),
            .hi_o   (pwm_out[2*k]),
            .lo_o   (pwm_out[2*k+1])
        );
    end

endmodule

// File: rtl/pwm_ps_checker.sv
module pwm_ps_checker #(
    parameter int CNT_W     = 16,
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run_en,
    input logic [2*NUM_PAIRS-1:0] pwm_out,
    input logic                   sync_pulse,
    input logic [CNT_W-1:0]       cnt,
    input logic [DT_W-1:0]        dt_val
);

    // R1: while running the count moves by one step or restarts at zero
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cnt != '0) |=> (!run_en || cnt == '0 ||
            cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1))
        else $error("p_count_step_r1");

    // R2: the reload pulse is never two clocks wide
    p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse)
        else $error("p_sync_single_r2");

    // R8: dropping the run enable parks the counter at zero
    p_idle_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt == '0 && !sync_pulse))
        else $error("p_idle_park_r8");

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair_chk
        // R11: a pair never drives both switches
        p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(pwm_out[2*k] && pwm_out[2*k+1]))
            else $error("p_no_overlap_r11");

        // R7: top release is followed by a gap, not the bottom switch
        p_top_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwm_out[2*k]) && $past(dt_val) != '0) |-> !pwm_out[2*k+1])
            else $error("p_top_gap_r7");

        // R7: bottom release is followed by a gap, not the top switch
        p_bot_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwm_out[2*k+1]) && $past(dt_val) != '0) |-> !pwm_out[2*k])
            else $error("p_bot_gap_r7");
    end

endmodule

bind pwm_phase_shift pwm_ps_checker #(
    .CNT_W(CNT_W), .NUM_PAIRS(NUM_PAIRS), .DT_W(DT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .pwm_out    (pwm_out),
    .sync_pulse (sync_pulse),
    .cnt        (cnt_w),
    .dt_val     (dt_w)
);

// File: tb/pwm_phase_shift_bench.sv
module pwm_phase_shift_bench;

    localparam int NP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  pwm_out;
    logic        sync_pulse;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    pwm_phase_shift u_pwm_phase_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .sync_pulse (sync_pulse)
    );

    // Reference model, built from the requirements
    logic [15:0] m_val [6];
    logic [15:0] m_mod;
    logic [6:0]  m_mode;
    logic [7:0]  m_dt;
    logic [2:0]  m_en;
    int          m_st;     // 0 idle, 1 up, 2 down, 3 edge
    int          m_cnt;
    bit          m_rq [NP];
    int          m_gap [NP];
    bit          m_aq [NP];

    function automatic int eff_mod();
        return (m_mod < 2) ? 2 : int'(m_mod);
    endfunction

    function automatic bit model_raw(input int k);
        int ve, vo, sel;
        ve = int'(m_val[2*k]);
        vo = int'(m_val[2*k+1]);
        if (m_st == 3) begin
            if (m_mode[4+k]) return (m_cnt >= ve) ^ (m_cnt >= vo);
            return ve > m_cnt;
        end
        sel = (m_mode[1+k] && m_st != 1) ? vo : ve;
        return sel > m_cnt;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_val[i] = '0;
            m_mod = '0; m_mode = '0; m_dt = '0; m_en = '0;
            m_st = 0; m_cnt = 0;
            for (int k = 0; k < NP; k++) begin
                m_rq[k] = 0; m_gap[k] = 0; m_aq[k] = 0;
            end
        end else begin
            int eff, rst_st;
            eff = eff_mod();
            for (int k = 0; k < NP; k++) begin
                bit act, raw;
                act = (m_st != 0) && m_en[k];
                raw = model_raw(k);
                if (!act) begin
                    m_rq[k] = 0; m_gap[k] = 0;
                end else begin
                    if (raw != m_rq[k]) m_gap[k] = int'(m_dt);
                    else if (m_gap[k] != 0) m_gap[k] = m_gap[k] - 1;
                    m_rq[k] = raw;
                end
                m_aq[k] = act;
            end
            rst_st = m_mode[0] ? 3 : 1;
            if (!run_en) begin
                m_st = 0; m_cnt = 0;
            end else begin
                case (m_st)
                    0: begin m_cnt = 0; m_st = rst_st; end
                    1: begin m_cnt = m_cnt + 1; if (m_cnt >= eff - 1) m_st = 2; end
                    2: begin
                        if (m_cnt <= 1) begin m_cnt = 0; m_st = rst_st; end
                        else m_cnt = m_cnt - 1;
                    end
                    default: begin
                        if (m_cnt >= eff - 1) begin m_cnt = 0; m_st = rst_st; end
                        else m_cnt = m_cnt + 1;
                    end
                endcase
            end
            if (wr_en) begin
                if (wr_addr < 6) m_val[wr_addr] = wr_data;
                else if (wr_addr == 6) m_mod = wr_data;
                else if (wr_addr == 7) m_mode = wr_data[6:0];
                else if (wr_addr == 8) m_dt = wr_data[7:0];
                else if (wr_addr == 9) m_en = wr_data[2:0];
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle monitor: compares every output against the model away from the edge
    bit    mon_on = 0;
    string out_tag = "R3";
    int    cyc = 0;
    int    last_sync = -1;

    always @(negedge clk) begin
        cyc++;
        if (mon_on && rst_n) begin
            check("R2", "sync_pulse", int'(sync_pulse), int'(m_st != 0 && m_cnt == 0));
            for (int k = 0; k < NP; k++) begin
                bit eh, el;
                eh = run_en && m_aq[k] && m_rq[k] && (m_gap[k] == 0);
                el = run_en && m_aq[k] && !m_rq[k] && (m_gap[k] == 0);
                check(out_tag, $sformatf("top pair %0d", k), int'(pwm_out[2*k]), int'(eh));
                check((m_dt == 0) ? "R6" : "R7", $sformatf("bottom pair %0d", k),
                      int'(pwm_out[2*k+1]), int'(el));
                if (pwm_out[2*k] && pwm_out[2*k+1])
                    check("R11", "both outputs high", 1, 0);
            end
            if (!run_en) last_sync = -1;
            else if (sync_pulse) begin
                if (last_sync >= 0)
                    check("R1", "period", cyc - last_sync,
                          (m_st == 3 || (m_st == 1 && m_mode[0])) ? eff_mod() : 2 * (eff_mod() - 1));
                last_sync = cyc;
            end
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int val_of(input int s, input int i);
        case (s)
            0: return (i % 2 == 0) ? 3 + i : 8 - i / 2;
            1: return (i == 0) ? 0 : (i == 2) ? 12 : (i % 2 == 0) ? 5 : 10 - 3 * (i / 2);
            default: return (i % 2 == 0) ? 9 : 3 + i;
        endcase
    endfunction

    task automatic stop_run();
        @(negedge clk);
        run_en = 1'b0;
        #1;
        check("R8", "outputs low at once", int'(pwm_out), 0);
        @(negedge clk);
        check("R8", "sync after stop", int'(sync_pulse), 0);
        check("R8", "outputs after stop", int'(pwm_out), 0);
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        stop_run();
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "reset outputs", int'(pwm_out), 0);
        check("R10", "reset sync", int'(sync_pulse), 0);
        mon_on = 1;

        // Near-exhaustive sweep: four compare modes, two dead times, three value sets
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 0; s < 3; s++) begin
                    int mode_word;
                    out_tag = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
                    if (d != 0) out_tag = "R7";
                    mode_word = ((m >= 2) ? 1 : 0) | ((m == 1) ? 7 << 1 : 0) | ((m == 3) ? 7 << 4 : 0);
                    for (int i = 0; i < 6; i++) wr(i, val_of(s, i));
                    wr(6, 12);
                    wr(7, mode_word);
                    wr(8, d * 2);
                    wr(9, 7);
                    run_for(50);
                end
            end
        end

        // R1: modulus below two acts as two, in both geometries
        out_tag = "R1";
        wr(8, 0);
        wr(6, 0);
        for (int i = 0; i < 6; i++) wr(i, 1);
        wr(7, 0);
        run_for(12);
        wr(7, 1);
        run_for(12);

        // R9: middle pair disabled stays low while the others run
        begin
            int seen_hi;
            out_tag = "R9";
            wr(6, 10);
            wr(7, 0);
            for (int i = 0; i < 6; i++) wr(i, 5);
            wr(9, 5);
            @(negedge clk);
            run_en = 1'b1;
            seen_hi = 0;
            repeat (40) begin
                @(negedge clk);
                if (pwm_out[3:2] != 0) seen_hi++;
            end
            check("R9", "disabled pair activity", seen_hi, 0);
            stop_run();
        end

        // R7: a pulse narrower than the dead time never reaches the top switch
        begin
            int top_hi, bot_hi;
            out_tag = "R7";
            wr(9, 7);
            wr(6, 12);
            for (int i = 0; i < 6; i++) wr(i, 2);
            wr(8, 7);
            @(negedge clk);
            run_en = 1'b1;
            top_hi = 0; bot_hi = 0;
            repeat (60) begin
                @(negedge clk);
                if (pwm_out[0]) top_hi++;
                if (pwm_out[1]) bot_hi++;
            end
            check("R7", "top highs under long gap", top_hi, 0);
            check("R7", "bottom active somewhere", int'(bot_hi > 0), 1);
            stop_run();
        end

        mon_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule